// File: doc/BRIEF.md
# Multi-Profile First-Order IIR Servo Engine

The engine closes a feedback loop per output channel. On each `start` pulse it captures one sample from every ADC input, then visits the output channels one after another on a single shared multiply-accumulate unit. For each channel it runs a first-order IIR step on the ADC input that the active coefficient set selects. It saturates the result to a non-negative value and stores it as that channel's filter output history. It then publishes an amplitude word together with a frequency word and a phase word that pass straight from the coefficient set.

Coefficients are kept per channel and per profile, and each channel's profile-select input chooses which set is live. The output history `y1` is also kept per channel and per profile. The input history (`x0`, `x1`) is kept per ADC, so channels that read the same ADC share it. A host port writes and reads both stores while the engine runs. When the engine and the host write the same history entry in the same cycle, the engine's value is kept.

Top module: `iir_servo_engine`

## Requirements
- R1: After reset `done` is 1 and every amplitude, frequency and phase output is 0.
- R2: A `start` seen while `done` is 1 drops `done` on the next cycle. The busy period lasts exactly 2 + 4·N cycles (34 for N = 8 channels), after which `done` stays 1 until the next `start`.
- R3: Host access uses `h_space` = 0 for coefficients and 1 for state. A coefficient address is {channel[2:0], profile[4:0], word[2:0]}, and an entry holds 18 bits. A state address with bit 10 = 0 is y1 at {channel, profile} in bits 7:0. With bit 10 = 1, bits 3:1 give the ADC and bit 0 selects x0 (0) or x1 (1). `h_rdata` returns the addressed entry one cycle after the address, and coefficients come back zero-extended.
- R4: Word indices are 0 a1, 1 b0, 2 b1, 3 offset, 4 frequency low, 5 frequency high, 6 phase, 7 config. With x0 = adc·2^8, off = offset·2^6 and 18-bit signed a1/b0/b1/offset, the engine computes y = (2^10 + a1·(0 − y1) + b0·(off − x0) + b1·(off − x1)) >> 11, using an arithmetic shift and a 48-bit accumulator.
- R5: y is saturated to the range 0 … 2^24 − 1 before it is used or stored.
- R6: The amplitude output of a channel is y1 >> 10 (14 bits) when its `en_out` is 1, and 0 when `en_out` is 0.
- R7: The frequency output is {word5[15:0], word4[15:0]} and the phase output is word6[15:0] of the active set.
- R8: With `en_iir` = 0 the stored y1 is left unchanged, and the amplitude is taken from that stored y1.
- R9: Bits 2:0 of word 7 select the ADC. Once every channel has been processed, each ADC's x1 takes the x0 of that iteration, so the next iteration's b1 tap sees the previous sample for every channel that reads that ADC.
- R10: A host y1 write and an engine y1 write-back to the same entry in the same cycle leave the engine's value.
- R11: `prof_sel` of a channel picks both the coefficient set and the y1 entry used for that channel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin one iteration (taken while done is 1) |
| done | output | 1 | Engine idle |
| adc_flat | input | 128 | ADC samples, 16-bit signed, ADC i at bits 16i+15:16i |
| en_iir | input | 8 | Per-channel history update enable |
| en_out | input | 8 | Per-channel amplitude enable |
| prof_sel | input | 40 | Per-channel profile, channel i at bits 5i+4:5i |
| h_we | input | 1 | Host write strobe |
| h_space | input | 1 | 0 coefficients, 1 state |
| h_addr | input | 11 | Host address |
| h_wdata | input | 25 | Host write data |
| h_rdata | output | 25 | Host read data, one cycle after address |
| amp_flat | output | 112 | Amplitude, 14 bits per channel |
| ftw_flat | output | 256 | Frequency word, 32 bits per channel |
| pow_flat | output | 128 | Phase word, 16 bits per channel |

## Verification
The host port and the engine's write-back both reach the y1 store, and they can land on the same entry in the same cycle. The bench counts cycles from the `start` edge and raises a host y1 write to channel 2's active entry exactly on that channel's write-back edge, carrying a value the filter would never produce. It then reads the entry back through the host port and compares it with the reference model's filter result. Around this, three iterations with saturating, gated, profile-switched and shared-ADC channels are scored against a model in the bench.

// File: rtl/iir_servo_pkg.sv
package iir_servo_pkg;

  typedef enum logic [2:0] {
    SEQ_IDLE,
    SEQ_LOAD,
    SEQ_MAC,
    SEQ_WB,
    SEQ_ROLL
  } seq_e;

  // word index inside one coefficient set
  localparam logic [2:0] K_A1   = 3'd0;
  localparam logic [2:0] K_B0   = 3'd1;
  localparam logic [2:0] K_B1   = 3'd2;
  localparam logic [2:0] K_OFF  = 3'd3;
  localparam logic [2:0] K_FTWL = 3'd4;
  localparam logic [2:0] K_FTWH = 3'd5;
  localparam logic [2:0] K_PHS  = 3'd6;
  localparam logic [2:0] K_SEL  = 3'd7;

endpackage

// File: rtl/iir_coef_store.sv
module iir_coef_store
  import iir_servo_pkg::*;
#(
  parameter int CH_W   = 3,
  parameter int PROF_W = 5,
  parameter int COEF_W = 18,
  parameter int WORD_W = 16
) (
  input  logic                          clk,
  input  logic                          wr_en,
  input  logic [CH_W+PROF_W+2:0]        haddr,
  input  logic [COEF_W-1:0]             wr_data,
  output logic [COEF_W-1:0]             host_q,
  input  logic [CH_W+PROF_W-1:0]        set_idx,
  output logic signed [COEF_W-1:0]      a1,
  output logic signed [COEF_W-1:0]      b0,
  output logic signed [COEF_W-1:0]      b1,
  output logic signed [COEF_W-1:0]      offs,
  output logic [2*WORD_W-1:0]           ftw,
  output logic [WORD_W-1:0]             phase,
  output logic [CH_W-1:0]               adc_sel
);

  localparam int AW    = CH_W + PROF_W + 3;
  localparam int DEPTH = 1 << AW;

  logic [COEF_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem[haddr] <= wr_data;
  end

  assign host_q  = mem[haddr];
  assign a1      = mem[{set_idx, K_A1}];
  assign b0      = mem[{set_idx, K_B0}];
  assign b1      = mem[{set_idx, K_B1}];
  assign offs    = mem[{set_idx, K_OFF}];
  assign ftw     = {mem[{set_idx, K_FTWH}][WORD_W-1:0], mem[{set_idx, K_FTWL}][WORD_W-1:0]};
  assign phase   = mem[{set_idx, K_PHS}][WORD_W-1:0];
  assign adc_sel = mem[{set_idx, K_SEL}][CH_W-1:0];

endmodule

// File: rtl/iir_state_store.sv
module iir_state_store #(
  parameter int CH_W   = 3,
  parameter int PROF_W = 5,
  parameter int ST_W   = 25,
  parameter int ADC_W  = 16
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        h_we,
  input  logic                        h_xsp,
  input  logic [CH_W+PROF_W-1:0]      h_yidx,
  input  logic [CH_W-1:0]             h_adc,
  input  logic                        h_xsel,
  input  logic [ST_W-1:0]             h_wdata,
  output logic [ST_W-1:0]             h_q,
  input  logic                        load,
  input  logic [(1<<CH_W)*ADC_W-1:0]  adc_flat,
  input  logic                        roll,
  input  logic                        e_we,
  input  logic [CH_W+PROF_W-1:0]      e_yidx,
  input  logic [ST_W-1:0]             e_data,
  input  logic [CH_W-1:0]             r_adc,
  output logic [ST_W-1:0]             y1_q,
  output logic [ST_W-1:0]             x0_q,
  output logic [ST_W-1:0]             x1_q
);

  localparam int NA    = 1 << CH_W;
  localparam int YD    = 1 << (CH_W + PROF_W);
  localparam int ALIGN = ST_W - ADC_W - 1;

  logic [NA-1:0][ST_W-1:0] x0_r, x0_d, x1_r, x1_d;
  logic [ST_W-1:0]         ymem [YD];

  // engine updates are applied after host updates so they win
  always_comb begin
    x0_d = x0_r;
    x1_d = x1_r;
    if (h_we && h_xsp) begin
      if (h_xsel) x1_d[h_adc] = h_wdata;
      else        x0_d[h_adc] = h_wdata;
    end
    if (load) begin
      for (int i = 0; i < NA; i++) begin
        x0_d[i] = ST_W'($signed(adc_flat[i*ADC_W +: ADC_W])) <<< ALIGN;
      end
    end
    if (roll) x1_d = x0_r;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      x0_r <= '0;
      x1_r <= '0;
    end else begin
      x0_r <= x0_d;
      x1_r <= x1_d;
    end
  end

  always_ff @(posedge clk) begin
    if (h_we && !h_xsp) ymem[h_yidx] <= h_wdata;
    if (e_we)           ymem[e_yidx] <= e_data;
  end

  assign h_q  = h_xsp ? (h_xsel ? x1_r[h_adc] : x0_r[h_adc]) : ymem[h_yidx];
  assign y1_q = ymem[e_yidx];
  assign x0_q = x0_r[r_adc];
  assign x1_q = x1_r[r_adc];

  assert_y1_in_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
    e_we |-> !e_data[ST_W-1]);

  // R10: same-cycle host and engine write to one entry keeps the engine value
  assert_engine_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (e_we && h_we && !h_xsp && (h_yidx == e_yidx)) |=> (ymem[$past(e_yidx)] == $past(e_data)));

endmodule

// File: rtl/iir_mac.sv
module iir_mac #(
  parameter int COEF_W = 18,
  parameter int ST_W   = 25,
  parameter int ACC_W  = 48,
  parameter int SHIFT  = 11
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     en,
  input  logic [1:0]               k,
  input  logic signed [COEF_W-1:0] a1,
  input  logic signed [COEF_W-1:0] b0,
  input  logic signed [COEF_W-1:0] b1,
  input  logic signed [COEF_W-1:0] offs,
  input  logic [ST_W-1:0]          x0,
  input  logic [ST_W-1:0]          x1,
  input  logic [ST_W-1:0]          y1,
  output logic [ST_W-1:0]          y_clip
);

  localparam int ALIGN = ST_W - COEF_W - 1;
  localparam logic signed [ACC_W-1:0] RND  = ACC_W'(1) <<< (SHIFT - 1);
  localparam logic signed [ACC_W-1:0] YMAX = (ACC_W'(1) <<< (ST_W - 1)) - ACC_W'(1);

  logic signed [ST_W:0]        off_al, dx0, dx1, ny1, diff;
  logic signed [COEF_W-1:0]    coef;
  logic signed [ACC_W-1:0]     ce, de, prod, acc_q, acc_d, ysh;

  always_comb begin
    off_al = {{(ST_W+1-COEF_W){offs[COEF_W-1]}}, offs} <<< ALIGN;
    dx0    = off_al - {x0[ST_W-1], x0};
    dx1    = off_al - {x1[ST_W-1], x1};
    ny1    = -{y1[ST_W-1], y1};
    unique case (k)
      2'd0:    begin coef = a1; diff = ny1; end
      2'd1:    begin coef = b0; diff = dx0; end
      default: begin coef = b1; diff = dx1; end
    endcase
    ce    = {{(ACC_W-COEF_W){coef[COEF_W-1]}}, coef};
    de    = {{(ACC_W-ST_W-1){diff[ST_W]}}, diff};
    prod  = ce * de;
    acc_d = ((k == 2'd0) ? RND : acc_q) + prod;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  acc_q <= '0;
    else if (en) acc_q <= acc_d;
  end

  always_comb begin
    ysh = acc_q >>> SHIFT;
    if (ysh < 0)         y_clip = '0;
    else if (ysh > YMAX) y_clip = YMAX[ST_W-1:0];
    else                 y_clip = ysh[ST_W-1:0];
  end

endmodule

// File: rtl/iir_seq.sv
module iir_seq
  import iir_servo_pkg::*;
#(
  parameter int CH_W = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  output logic            done,
  output logic            load,
  output logic            mac_en,
  output logic [1:0]      k,
  output logic            wb,
  output logic            roll,
  output logic [CH_W-1:0] ch
);

  localparam logic [CH_W-1:0] LAST = {CH_W{1'b1}};

  seq_e            st_q, st_d;
  logic [CH_W-1:0] ch_q, ch_d;
  logic [1:0]      k_q, k_d;

  always_comb begin
    st_d = st_q;
    ch_d = ch_q;
    k_d  = k_q;
    unique case (st_q)
      SEQ_IDLE: if (start) st_d = SEQ_LOAD;
      SEQ_LOAD: begin st_d = SEQ_MAC; ch_d = '0; k_d = '0; end
      SEQ_MAC:  if (k_q == 2'd2) st_d = SEQ_WB; else k_d = k_q + 2'd1;
      SEQ_WB: begin
        k_d = '0;
        if (ch_q == LAST) st_d = SEQ_ROLL;
        else begin st_d = SEQ_MAC; ch_d = ch_q + 1'b1; end
      end
      SEQ_ROLL: st_d = SEQ_IDLE;
      default:  st_d = SEQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= SEQ_IDLE;
      ch_q <= '0;
      k_q  <= '0;
    end else begin
      st_q <= st_d;
      ch_q <= ch_d;
      k_q  <= k_d;
    end
  end

  assign done   = (st_q == SEQ_IDLE);
  assign load   = (st_q == SEQ_LOAD);
  assign mac_en = (st_q == SEQ_MAC);
  assign wb     = (st_q == SEQ_WB);
  assign roll   = (st_q == SEQ_ROLL);
  assign k      = k_q;
  assign ch     = ch_q;

  assert_start_clears_done_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (done && start) |=> !done);

  assert_done_holds_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> done);

endmodule

// File: rtl/iir_servo_engine.sv
module iir_servo_engine #(
  parameter int CH_W   = 3,
  parameter int PROF_W = 5,
  parameter int ST_W   = 25,
  parameter int COEF_W = 18,
  parameter int ADC_W  = 16,
  parameter int ASF_W  = 14,
  parameter int ACC_W  = 48,
  parameter int SHIFT  = 11,
  parameter int WORD_W = 16
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic                                start,
  output logic                                done,
  input  logic [(1<<CH_W)*ADC_W-1:0]          adc_flat,
  input  logic [(1<<CH_W)-1:0]                en_iir,
  input  logic [(1<<CH_W)-1:0]                en_out,
  input  logic [(1<<CH_W)*PROF_W-1:0]         prof_sel,
  input  logic                                h_we,
  input  logic                                h_space,
  input  logic [CH_W+PROF_W+2:0]              h_addr,
  input  logic [ST_W-1:0]                     h_wdata,
  output logic [ST_W-1:0]                     h_rdata,
  output logic [(1<<CH_W)*ASF_W-1:0]          amp_flat,
  output logic [(1<<CH_W)*2*WORD_W-1:0]       ftw_flat,
  output logic [(1<<CH_W)*WORD_W-1:0]        pow_flat
);

  localparam int N      = 1 << CH_W;
  localparam int AW     = CH_W + PROF_W + 3;
  localparam int YW     = CH_W + PROF_W;
  localparam int AMP_SH = ST_W - ASF_W - 1;

  logic              load, mac_en, wb, roll;
  logic [1:0]        k;
  logic [CH_W-1:0]   ch, adc_sel;
  logic [PROF_W-1:0] prof;
  logic [YW-1:0]     set_idx;

  logic signed [COEF_W-1:0] a1, b0, b1, offs;
  logic [2*WORD_W-1:0]      ftw;
  logic [WORD_W-1:0]        phase;
  logic [COEF_W-1:0]        coef_hq;
  logic [ST_W-1:0]          st_hq, y1_rd, x0_rd, x1_rd, y_clip, y_fin;
  logic                     e_we;

  logic [N-1:0][ASF_W-1:0]    amp_q, amp_d;
  logic [N-1:0][2*WORD_W-1:0] ftw_q, ftw_d;
  logic [N-1:0][WORD_W-1:0]   pow_q, pow_d;
  logic [ST_W-1:0]            rd_q, rd_d;

  assign prof    = prof_sel[ch*PROF_W +: PROF_W];
  assign set_idx = {ch, prof};
  assign e_we    = wb & en_iir[ch];
  assign y_fin   = en_iir[ch] ? y_clip : y1_rd;

  iir_seq #(.CH_W(CH_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .done(done), .load(load),
    .mac_en(mac_en), .k(k), .wb(wb), .roll(roll), .ch(ch)
  );

  iir_coef_store #(.CH_W(CH_W), .PROF_W(PROF_W), .COEF_W(COEF_W), .WORD_W(WORD_W)) u_coef (
    .clk(clk), .wr_en(h_we & ~h_space), .haddr(h_addr), .wr_data(h_wdata[COEF_W-1:0]),
    .host_q(coef_hq), .set_idx(set_idx), .a1(a1), .b0(b0), .b1(b1), .offs(offs),
    .ftw(ftw), .phase(phase), .adc_sel(adc_sel)
  );

  iir_state_store #(.CH_W(CH_W), .PROF_W(PROF_W), .ST_W(ST_W), .ADC_W(ADC_W)) u_state (
    .clk(clk), .rst_n(rst_n), .h_we(h_we & h_space), .h_xsp(h_addr[AW-1]),
    .h_yidx(h_addr[YW-1:0]), .h_adc(h_addr[CH_W:1]), .h_xsel(h_addr[0]),
    .h_wdata(h_wdata), .h_q(st_hq), .load(load), .adc_flat(adc_flat), .roll(roll),
    .e_we(e_we), .e_yidx(set_idx), .e_data(y_clip), .r_adc(adc_sel),
    .y1_q(y1_rd), .x0_q(x0_rd), .x1_q(x1_rd)
  );

  iir_mac #(.COEF_W(COEF_W), .ST_W(ST_W), .ACC_W(ACC_W), .SHIFT(SHIFT)) u_mac (
    .clk(clk), .rst_n(rst_n), .en(mac_en), .k(k), .a1(a1), .b0(b0), .b1(b1),
    .offs(offs), .x0(x0_rd), .x1(x1_rd), .y1(y1_rd), .y_clip(y_clip)
  );

  always_comb begin
    amp_d = amp_q;
    ftw_d = ftw_q;
    pow_d = pow_q;
    rd_d  = h_space ? st_hq : ST_W'(coef_hq);
    if (wb) begin
      amp_d[ch] = en_out[ch] ? ASF_W'(y_fin >> AMP_SH) : '0;
      ftw_d[ch] = ftw;
      pow_d[ch] = phase;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      amp_q <= '0;
      ftw_q <= '0;
      pow_q <= '0;
      rd_q  <= '0;
    end else begin
      amp_q <= amp_d;
      ftw_q <= ftw_d;
      pow_q <= pow_d;
      rd_q  <= rd_d;
    end
  end

  assign amp_flat = amp_q;
  assign ftw_flat = ftw_q;
  assign pow_flat = pow_q;
  assign h_rdata  = rd_q;

  assert_amp_gated_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wb && !en_out[ch]) |=> (amp_q[$past(ch)] == '0));

endmodule

// File: tb/sim_iir_servo_engine.sv
module sim_iir_servo_engine;

  localparam int N = 8;
  localparam int P = 32;
  localparam longint YMAX = (64'sd1 <<< 24) - 1;

  logic         clk = 1'b0;
  logic         rst_n, start, done;
  logic [127:0] adc_flat;
  logic [7:0]   en_iir, en_out;
  logic [39:0]  prof_sel;
  logic         h_we, h_space;
  logic [10:0]  h_addr;
  logic [24:0]  h_wdata, h_rdata;
  logic [111:0] amp_flat;
  logic [255:0] ftw_flat;
  logic [127:0] pow_flat;

  always #2 clk = ~clk;

  iir_servo_engine u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .done(done), .adc_flat(adc_flat),
    .en_iir(en_iir), .en_out(en_out), .prof_sel(prof_sel), .h_we(h_we),
    .h_space(h_space), .h_addr(h_addr), .h_wdata(h_wdata), .h_rdata(h_rdata),
    .amp_flat(amp_flat), .ftw_flat(ftw_flat), .pow_flat(pow_flat)
  );

  typedef struct {int ch; longint amp; longint ftw; longint pw; string req;} exp_t;
  exp_t sbq[$];

  int     n_chk = 0, n_err = 0;
  longint m_coef [N][P][8];
  longint m_y1 [N][P];
  longint m_x1 [N];
  int     m_adc [N];
  int     m_prof [N];
  bit     m_en_iir [N], m_en_out [N];
  string  m_tag [N];

  task automatic chk(input string req, input longint act, input longint expv);
    n_chk++;
    if (act !== expv) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  task automatic host_wr(input bit sp, input int addr, input longint val);
    @(negedge clk);
    h_space = sp; h_addr = 11'(addr); h_wdata = 25'(val); h_we = 1'b1;
    @(negedge clk);
    h_we = 1'b0;
  endtask

  task automatic host_rd(input bit sp, input int addr, output longint val);
    @(negedge clk);
    h_space = sp; h_addr = 11'(addr);
    @(negedge clk);
    val = longint'(h_rdata);
  endtask

  task automatic wr_coef(input int c, input int p, input int idx, input longint v);
    m_coef[c][p][idx] = v;
    host_wr(1'b0, (c << 8) | (p << 3) | idx, v & 18'h3ffff);
  endtask

  task automatic wr_set(input int c, input int p, input longint a1, input longint b0,
                        input longint b1, input longint off, input int sel);
    wr_coef(c, p, 0, a1);
    wr_coef(c, p, 1, b0);
    wr_coef(c, p, 2, b1);
    wr_coef(c, p, 3, off);
    wr_coef(c, p, 4, 16'h1100 + c * 16 + p);
    wr_coef(c, p, 5, 16'h2200 + c * 16 + p);
    wr_coef(c, p, 6, 16'h3300 + c * 16 + p);
    wr_coef(c, p, 7, sel);
  endtask

  task automatic wr_y1(input int c, input int p, input longint v);
    m_y1[c][p] = v;
    host_wr(1'b1, (c << 5) | p, v);
  endtask

  function automatic longint model_y(int c);
    int     p   = m_prof[c];
    int     sel = int'(m_coef[c][p][7] & 7);
    longint x0  = longint'(m_adc[sel]) * 256;
    longint off = m_coef[c][p][3] * 64;
    longint acc = 1024 - m_coef[c][p][0] * m_y1[c][p]
                + m_coef[c][p][1] * (off - x0) + m_coef[c][p][2] * (off - m_x1[sel]);
    longint y   = acc >>> 11;
    if (y < 0) y = 0;
    if (y > YMAX) y = YMAX;
    return y;
  endfunction

  // driver: predicts results into the scoreboard, then runs one iteration
  task automatic run_iter(input int coll_ch, input longint coll_val);
    int cyc;
    for (int c = 0; c < N; c++) begin
      int     p = m_prof[c];
      longint y = model_y(c);
      exp_t   e;
      if (m_en_iir[c]) m_y1[c][p] = y;
      e.ch  = c;
      e.amp = m_en_out[c] ? (m_y1[c][p] >> 10) : 0;
      e.ftw = (m_coef[c][p][5] << 16) | m_coef[c][p][4];
      e.pw  = m_coef[c][p][6];
      e.req = m_tag[c];
      sbq.push_back(e);
    end
    @(negedge clk);
    for (int i = 0; i < N; i++) begin
      adc_flat[i*16 +: 16] = 16'(m_adc[i]);
      en_iir[i] = m_en_iir[i];
      en_out[i] = m_en_out[i];
      prof_sel[i*5 +: 5] = 5'(m_prof[i]);
    end
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    cyc = 0;
    chk("R2", longint'(done), 0);
    while (!done && cyc < 200) begin
      @(negedge clk);
      cyc++;
      if (coll_ch >= 0 && cyc == 4 + 4 * coll_ch) begin
        h_space = 1'b1; h_addr = 11'((coll_ch << 5) | m_prof[coll_ch]);
        h_wdata = 25'(coll_val); h_we = 1'b1;
      end
      if (coll_ch >= 0 && cyc == 5 + 4 * coll_ch) h_we = 1'b0;
    end
    chk("R2", cyc, 34);
    for (int i = 0; i < N; i++) m_x1[i] = longint'(m_adc[i]) * 256;
    @(negedge clk);
  endtask

  // monitor: pops predictions when an iteration completes
  initial begin
    exp_t e;
    forever begin
      @(posedge done);
      #1;
      while (sbq.size() > 0) begin
        e = sbq.pop_front();
        chk(e.req, longint'(amp_flat[e.ch*14 +: 14]), e.amp);
        chk("R7", longint'(ftw_flat[e.ch*32 +: 32]), e.ftw);
        chk("R7", longint'(pow_flat[e.ch*16 +: 16]), e.pw);
      end
    end
  end

  initial begin
    #400000;
    n_err++;
    $display("FAIL watchdog actual=hung expected=finish");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk + 1);
    $finish;
  end

  initial begin
    longint v;
    rst_n = 1'b0; start = 1'b0; h_we = 1'b0; h_space = 1'b0; h_addr = '0; h_wdata = '0;
    adc_flat = '0; en_iir = '0; en_out = '0; prof_sel = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", longint'(done), 1);
    chk("R1", longint'(|amp_flat), 0);
    chk("R1", longint'(|ftw_flat | |pow_flat), 0);

    for (int c = 0; c < N; c++) begin
      m_prof[c] = c; m_en_iir[c] = 1; m_en_out[c] = 1; m_tag[c] = "R4";
      m_adc[c] = 16'h0200 + c * 16'h0333;
      wr_set(c, c, 40 + c * 13, 600 + c * 77, 250 - c * 45, 1500 + c * 210, (c * 5) % 8);
      wr_y1(c, c, 24'h4000 * (c + 1));
      m_x1[c] = c * 25'h2345;
      host_wr(1'b1, 1024 | (c << 1) | 1, m_x1[c]);
    end
    m_adc[6] = -16'sh0180;
    m_adc[7] = 16'h1800;
    wr_set(5, 5, 0, 2000, 0, 0, 7);        m_tag[5] = "R5";
    wr_set(6, 6, 0, -131072, 0, 0, 7);     m_tag[6] = "R5";
    m_en_out[3] = 0;                        m_tag[3] = "R6";
    m_en_iir[4] = 0;                        m_tag[4] = "R8";

    host_rd(1'b0, (2 << 8) | (2 << 3) | 1, v);  chk("R3", v, 754);
    host_rd(1'b0, (6 << 8) | (6 << 3) | 1, v);  chk("R3", v, 18'h20000);
    host_rd(1'b1, 1024 | (3 << 1) | 1, v);      chk("R3", v, 3 * 25'h2345);
    host_rd(1'b1, (1 << 5) | 1, v);             chk("R3", v, 24'h8000);

    run_iter(-1, 0);
    host_rd(1'b1, 0, v);                        chk("R4", v, m_y1[0][0]);
    host_rd(1'b1, (6 << 5) | 6, v);             chk("R5", v, YMAX);
    host_rd(1'b1, 1024 | (6 << 1) | 1, v);      chk("R9", v, m_x1[6] & 25'h1ffffff);
    host_rd(1'b1, (4 << 5) | 4, v);             chk("R8", v, m_y1[4][4]);

    // second pass: new samples, profile switch on channel 1, shared ADC 0
    for (int i = 0; i < N; i++) m_adc[i] = 16'h0150 + i * 16'h0211;
    m_adc[6] = -16'sh0300;
    wr_set(1, 9, 75, -300, 900, 800, 6);
    wr_y1(1, 9, 24'h3000);
    m_prof[1] = 9;                          m_tag[1] = "R11";
    wr_set(7, 7, 20, 450, 700, 1200, 0);    m_tag[7] = "R9";
    wr_coef(0, 0, 7, 0);
    run_iter(-1, 0);
    host_rd(1'b1, (1 << 5) | 9, v);             chk("R11", v, m_y1[1][9]);
    host_rd(1'b1, (1 << 5) | 1, v);             chk("R11", v, m_y1[1][1]);
    host_rd(1'b1, (7 << 5) | 7, v);             chk("R9", v, m_y1[7][7]);

    // third pass: host write lands on channel 2's write-back edge
    m_tag[2] = "R10";
    run_iter(2, 25'h0abcde);
    host_rd(1'b1, (2 << 5) | 2, v);             chk("R10", v, m_y1[2][2]);
    host_rd(1'b1, (3 << 5) | 3, v);             chk("R6", v, m_y1[3][3]);

    repeat (2) @(negedge clk);
    chk("R2", longint'(done), 1);
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule